// File: doc/BRIEF.md
# Two-Level Overcurrent and Thermal Trip Logic

This block sits between the current-sense comparators and the gate driver of a mains-switched power stage. It takes the digital outputs of a fast high-threshold comparator and a slower low-threshold comparator. It also takes a thermal-limit flag, a one-cycle zero-crossing pulse, a one-millisecond tick and the power-on reset. From these it drives an immediate trip line, an output-enable line and three separate fault flags.

A high-threshold event (short circuit) pulls the trip line at once and latches. A low-threshold event (overload) feeds an integrating level counter. The counter rises by one for each millisecond tick during which the low comparator is active. It falls by a fixed step at each zero crossing that closes a half-wave with no such tick. When the level reaches its ceiling, the output is not re-enabled after the next zero crossing. This avoids an inductive spike from cutting current in mid half-wave. Overloads that skip some half-waves still trip, but later.

An over-temperature flag disables the output at once. Every fault is sticky and clears only on power-on reset.

Top module: `ocg_guard`

## Requirements
- R1: After reset, `out_en_o` is 1, all three fault flags are 0, and `fast_trip_o` equals `hi_cmp_i`.
- R2: `fast_trip_o` is 1 in the same cycle as `hi_cmp_i` is 1, with no clock edge in between.
- R3: A clock edge that samples `hi_cmp_i`=1 sets `sc_flt_o`. From then on `fast_trip_o` stays 1 and `out_en_o` is 0, also after `hi_cmp_i` returns to 0.
- R4: A clock edge that samples `therm_i`=1 sets `th_flt_o` and drops `out_en_o`, even after `therm_i` returns to 0. The other two fault flags are not set by it.
- R5: The overload level rises by 1 at each edge that samples `ms_tick_i`=1 with `lo_cmp_i`=1, saturating at `CEIL_MS` (default 120). `lo_cmp_i` held high without a tick, or ticks with `lo_cmp_i`=0, add nothing.
- R6: The overload trip is deferred. Reaching the ceiling leaves `out_en_o` at 1 and `oc_flt_o` at 0 until the edge that samples `zc_i`=1. That edge sets `oc_flt_o` and clears `out_en_o`.
- R7: At an edge sampling `zc_i`=1, the level falls by `DECAY_STEP` (default 2), floored at 0, if no qualifying tick occurred since the previous zero crossing. Intermittent overload trips only if its net gain per cycle of half-waves is positive.
- R8: Fault flags never clear without `rst_ni`=0; `rst_ni`=0 clears all of them and the level.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| hi_cmp_i | input | 1 | High-threshold (short-circuit) comparator |
| lo_cmp_i | input | 1 | Low-threshold (overload) comparator |
| therm_i | input | 1 | Over-temperature flag |
| zc_i | input | 1 | Zero-crossing pulse, one cycle |
| ms_tick_i | input | 1 | One-millisecond tick, one cycle |
| fast_trip_o | output | 1 | Immediate trip to the gate network |
| out_en_o | output | 1 | Output stage enable |
| sc_flt_o | output | 1 | Short-circuit fault latched |
| oc_flt_o | output | 1 | Sustained overload fault latched |
| th_flt_o | output | 1 | Thermal fault latched |

## Verification
A wrong overload level is not visible until a zero crossing. At that point `oc_flt_o` and `out_en_o` switch one half-wave early or late, or never. Sweeping the per-half-wave tick count against several idle-half-wave patterns therefore exposes an off-by-one in the rise, the decay or the ceiling within a few tens of half-waves.

A broken short-circuit or thermal latch shows in the first cycle after its input falls again, as a released `fast_trip_o` or a re-raised `out_en_o`.

// File: rtl/ocg_pkg.sv
package ocg_pkg;
  typedef enum logic [1:0] {
    FLT_SC = 2'd0,
    FLT_OC = 2'd1,
    FLT_TH = 2'd2
  } flt_e;
  localparam int unsigned NUM_FLT = 3;
endpackage

// File: rtl/ocg_latch.sv
module ocg_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/ocg_integ.sv
module ocg_integ #(
  parameter int unsigned CEIL_MS    = 120,
  parameter int unsigned DECAY_STEP = 2,
  localparam int unsigned LVL_W     = $clog2(CEIL_MS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lo_i,
  input  logic             zc_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             full_o
);
  localparam logic [LVL_W-1:0] CEIL  = LVL_W'(CEIL_MS);
  localparam logic [LVL_W-1:0] DECAY = LVL_W'(DECAY_STEP);

  logic             qual;
  logic             hw_act_q;
  logic [LVL_W-1:0] lvl_q, lvl_d, inc, dec;

  assign qual = tick_i & lo_i;
  assign inc  = (lvl_q == CEIL) ? CEIL : lvl_q + 1'b1;
  assign dec  = (lvl_q > DECAY) ? lvl_q - DECAY : '0;

  always_comb begin
    lvl_d = lvl_q;
    if (qual)
      lvl_d = inc;
    else if (zc_i && !hw_act_q)
      lvl_d = dec;  // quiet half-wave closes: bleed off
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= '0;
      hw_act_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      if (zc_i)      hw_act_q <= 1'b0;
      else if (qual) hw_act_q <= 1'b1;
    end
  end

  assign lvl_o  = lvl_q;
  assign full_o = (lvl_q == CEIL);
endmodule

// File: rtl/ocg_guard.sv
module ocg_guard
  import ocg_pkg::*;
#(
  parameter int unsigned CEIL_MS    = 120,
  parameter int unsigned DECAY_STEP = 2,
  localparam int unsigned LVL_W     = $clog2(CEIL_MS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_cmp_i,
  input  logic lo_cmp_i,
  input  logic therm_i,
  input  logic zc_i,
  input  logic ms_tick_i,
  output logic fast_trip_o,
  output logic out_en_o,
  output logic sc_flt_o,
  output logic oc_flt_o,
  output logic th_flt_o
);
  logic [LVL_W-1:0]   lvl;
  logic               full;
  logic [NUM_FLT-1:0] set_vec, flt_q;

  ocg_integ #(
    .CEIL_MS   (CEIL_MS),
    .DECAY_STEP(DECAY_STEP)
  ) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(ms_tick_i),
    .lo_i  (lo_cmp_i),
    .zc_i  (zc_i),
    .lvl_o (lvl),
    .full_o(full)
  );

  assign set_vec[FLT_SC] = hi_cmp_i;
  assign set_vec[FLT_OC] = zc_i & full;  // half-wave aligned cut
  assign set_vec[FLT_TH] = therm_i;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    ocg_latch u_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[g]),
      .q_o   (flt_q[g])
    );
  end

  assign fast_trip_o = hi_cmp_i | flt_q[FLT_SC];
  assign out_en_o    = ~|flt_q;
  assign sc_flt_o    = flt_q[FLT_SC];
  assign oc_flt_o    = flt_q[FLT_OC];
  assign th_flt_o    = flt_q[FLT_TH];
endmodule

// File: rtl/ocg_guard_chk.sv
module ocg_guard_chk #(
  parameter int unsigned CEIL_MS = 120,
  localparam int unsigned LVL_W  = $clog2(CEIL_MS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hi_cmp_i,
  input logic             therm_i,
  input logic             zc_i,
  input logic             fast_trip_o,
  input logic             out_en_o,
  input logic             sc_flt_o,
  input logic             oc_flt_o,
  input logic             th_flt_o,
  input logic [LVL_W-1:0] lvl_i
);
  AST_FAST_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni) hi_cmp_i |-> fast_trip_o); // R2
  AST_SC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) hi_cmp_i |=> (sc_flt_o && fast_trip_o && !out_en_o)); // R3
  AST_TH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) therm_i |=> (th_flt_o && !out_en_o)); // R4
  AST_LVL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) lvl_i <= LVL_W'(CEIL_MS)); // R5
  AST_OC_AT_ZC: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(oc_flt_o) |-> $past(zc_i)); // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (sc_flt_o || oc_flt_o || th_flt_o) |=> !out_en_o); // R8
  AST_OC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) oc_flt_o |=> oc_flt_o); // R8
endmodule

bind ocg_guard ocg_guard_chk #(.CEIL_MS(CEIL_MS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hi_cmp_i   (hi_cmp_i),
  .therm_i    (therm_i),
  .zc_i       (zc_i),
  .fast_trip_o(fast_trip_o),
  .out_en_o   (out_en_o),
  .sc_flt_o   (sc_flt_o),
  .oc_flt_o   (oc_flt_o),
  .th_flt_o   (th_flt_o),
  .lvl_i      (lvl)
);

// File: tb/sim_ocg_guard.sv
module sim_ocg_guard;
  localparam int CEIL  = 12;
  localparam int DECAY = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hi_cmp_i = 1'b0, lo_cmp_i = 1'b0, therm_i = 1'b0, zc_i = 1'b0, ms_tick_i = 1'b0;
  logic fast_trip_o, out_en_o, sc_flt_o, oc_flt_o, th_flt_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  ocg_guard #(.CEIL_MS(CEIL), .DECAY_STEP(DECAY)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .hi_cmp_i(hi_cmp_i), .lo_cmp_i(lo_cmp_i),
    .therm_i(therm_i), .zc_i(zc_i), .ms_tick_i(ms_tick_i),
    .fast_trip_o(fast_trip_o), .out_en_o(out_en_o), .sc_flt_o(sc_flt_o),
    .oc_flt_o(oc_flt_o), .th_flt_o(th_flt_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc;
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; hi_cmp_i = 0; lo_cmp_i = 0; therm_i = 0; zc_i = 0; ms_tick_i = 0;
    cyc; cyc;
    rst_ni = 1'b1;
    cyc;
  endtask

  task automatic tick(input logic lo);
    lo_cmp_i = lo;
    ms_tick_i = 1'b1; cyc;
    ms_tick_i = 1'b0; cyc; cyc;  // lo held without tick: no effect (R5)
    lo_cmp_i = 1'b0;
  endtask

  task automatic zc_pulse;
    zc_i = 1'b1; cyc;
    zc_i = 1'b0;
  endtask

  // overload sweep: t ticks per active half-wave; every per-th half-wave idle (0: none)
  task automatic run_ovl(input int t, input int per);
    int  m = 0;
    logic tripped = 1'b0;
    do_reset;
    for (int hw = 1; hw <= 60; hw++) begin
      logic act = (per == 0) || (hw % per != 0);
      logic exp_trip;
      for (int k = 0; k < t; k++) begin
        tick(act);
        if (act) m = (m + 1 > CEIL) ? CEIL : m + 1;
      end
      // deferred: still enabled before the zero crossing (R6)
      chk("R6 pre-zc out_en", out_en_o, ~tripped);
      exp_trip = tripped | (m == CEIL);
      if (!act) m = (m > DECAY) ? m - DECAY : 0;  // R7
      zc_pulse;
      tripped = exp_trip;
      chk("R5/R7 oc_flt at zc", oc_flt_o, tripped);
      chk("R6 out_en at zc", out_en_o, ~tripped);
      chk("R4 no thermal from overload", th_flt_o, 1'b0);
      if (tripped && hw % 8 == 0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset;
    // R1 reset state
    chk("R1 out_en", out_en_o, 1'b1);
    chk("R1 sc", sc_flt_o, 1'b0);
    chk("R1 oc", oc_flt_o, 1'b0);
    chk("R1 th", th_flt_o, 1'b0);
    chk("R1 fast_trip idle", fast_trip_o, 1'b0);

    // R2/R3 short circuit
    hi_cmp_i = 1'b1; #0.5;
    chk("R2 fast_trip same cycle", fast_trip_o, 1'b1);
    chk("R2 no latch before edge", sc_flt_o, 1'b0);
    #0.5; cyc;
    hi_cmp_i = 1'b0; #0.5;
    chk("R3 sc set", sc_flt_o, 1'b1);
    chk("R3 fast_trip held", fast_trip_o, 1'b1);
    chk("R3 out_en low", out_en_o, 1'b0);
    chk("R3 oc separate", oc_flt_o, 1'b0);
    chk("R3 th separate", th_flt_o, 1'b0);
    for (int i = 0; i < 5; i++) begin cyc; zc_pulse; end
    chk("R8 sc sticky", sc_flt_o, 1'b1);
    chk("R8 out_en stays low", out_en_o, 1'b0);
    do_reset;
    chk("R8 reset clears sc", sc_flt_o, 1'b0);
    chk("R8 reset restores out_en", out_en_o, 1'b1);

    // R4 thermal
    therm_i = 1'b1; cyc; therm_i = 1'b0;
    chk("R4 th set", th_flt_o, 1'b1);
    chk("R4 out_en low", out_en_o, 1'b0);
    chk("R4 sc untouched", sc_flt_o, 1'b0);
    chk("R4 fast_trip untouched", fast_trip_o, 1'b0);
    for (int i = 0; i < 4; i++) begin cyc; zc_pulse; end
    chk("R4 th sticky", th_flt_o, 1'b1);
    do_reset;
    chk("R8 reset clears th", th_flt_o, 1'b0);

    // R5 lo without tick has no effect
    lo_cmp_i = 1'b1;
    for (int i = 0; i < 3 * CEIL; i++) cyc;
    lo_cmp_i = 1'b0;
    zc_pulse;
    chk("R5 lo without tick", oc_flt_o, 1'b0);

    // R5/R6/R7 sweep
    for (int t = 1; t <= 6; t++)
      for (int per = 0; per <= 3; per++)
        if (per != 1) run_ovl(t, per);

    do_reset;
    chk("R8 reset clears oc", oc_flt_o, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule